// File: doc/BRIEF.md
# Ring-Oscillator Phase Quantizer Back End

This block turns the tap levels of a free-running ring oscillator into a multi-bit quantizer code. The tuning input of the oscillator sets how fast its phase travels around the ring. The block registers every stage tap on each sample clock and compares each new capture with the one taken a clock earlier. Every stage whose level differs is marked as having switched during the last period. The number of marked stages is the output code, so the code follows the tuning level.

The per-stage switch vector is also brought out, aligned with the code. Because the oscillator phase keeps rotating around the ring, the vector walks across the stages from one clock to the next. It can drive a row of unit DAC elements directly, with no separate mismatch-shaping stage. An overrange flag marks codes that sit at the full-scale limit. Above that limit, transitions alias into a smaller count.

Top module: `rop_quantizer_backend`

## Requirements
- R1: While reset is high, and after reset until the third rising clock edge with reset low, `trans_vec_o`, `code_o` and `ovr_o` are all zero, whatever the taps do.
- R2: Once running, bit i of `trans_vec_o` is 1 exactly when stage tap i differs between two consecutive clock samples.
- R3: `code_o` equals the number of ones in `trans_vec_o` in the same cycle and never exceeds `N`.
- R4: When the ring phase advances by m stage transitions per clock with m no larger than `N`, `code_o` settles to m.
- R5: `ovr_o` is 1 exactly in the cycles where `code_o` equals `N`.
- R6: The outputs after rising edge j show the tap samples taken at edges j-1 and j-2. Vector, code and flag change on the same edge.
- R7: Taps that hold still give a code of zero and an all-zero vector.
- R8: When the phase advances by N+k transitions per clock (0 < k ≤ N), the code aliases to N-k, because some stages switch twice.

Ports:

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| taps_i | input | N | Logic level of each ring stage tap |
| trans_vec_o | output | N | Per-stage switch vector, one unit DAC element per bit |
| code_o | output | $clog2(N+1) | Count of switched stages |
| ovr_o | output | 1 | Code is at full scale N |

## Verification
The assertions assume that the tap levels are settled at each sampling edge. The bench meets this by changing the taps only well after a rising edge. Only R4 depends on the ring having at most N transitions per period. The range and agreement checks hold for any tap pattern. The stimulus models the ring as a twisted phase pattern in which each step of phase flips exactly one stage. It advances that pattern by a chosen step per clock. Most steps stay within N. One deliberate run exceeds N to show the aliasing of R8.

// File: rtl/rop_pkg.sv
package rop_pkg;

    localparam int DEF_STAGES = 15;

    typedef enum logic [1:0] {
        FILL_EMPTY = 2'd0,
        FILL_ONE   = 2'd1,
        FILL_READY = 2'd2
    } fill_t;

    function automatic int code_width(input int stages);
        return $clog2(stages + 1);
    endfunction

    function automatic fill_t fill_next(input fill_t f);
        case (f)
            FILL_EMPTY: return FILL_ONE;
            FILL_ONE:   return FILL_READY;
            default:    return FILL_READY;
        endcase
    endfunction

endpackage

// File: rtl/rop_tap_capture.sv
module rop_tap_capture
    import rop_pkg::*;
#(
    parameter int N = DEF_STAGES
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] taps_i,
    output logic [N-1:0] cur_o,
    output logic [N-1:0] prev_o,
    output logic         ready_o
);

    fill_t fill;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_o  <= '0;
            prev_o <= '0;
            fill   <= FILL_EMPTY;
        end else begin
            cur_o  <= taps_i;
            prev_o <= cur_o;
            fill   <= fill_next(fill);
        end
    end

    assign ready_o = (fill == FILL_READY);

    // R2: the older bank always holds the newer bank's prior content
    p_prev_follows_r2: assert property (@(posedge clk) disable iff (rst)
        (fill != FILL_EMPTY) |-> (prev_o == $past(cur_o)));

endmodule

// File: rtl/rop_edge_detect.sv
module rop_edge_detect
    import rop_pkg::*;
#(
    parameter int N = DEF_STAGES
) (
    input  logic [N-1:0] cur_i,
    input  logic [N-1:0] prev_i,
    output logic [N-1:0] flip_o
);

    for (genvar s = 0; s < N; s++) begin : g_stage
        assign flip_o[s] = cur_i[s] ^ prev_i[s];
    end

endmodule

// File: rtl/rop_popcount.sv
module rop_popcount
    import rop_pkg::*;
#(
    parameter int W  = DEF_STAGES,
    parameter int OW = code_width(DEF_STAGES)
) (
    input  logic [W-1:0]  bits_i,
    output logic [OW-1:0] count_o
);

    localparam int GRP   = 4;
    localparam int NGRP  = (W + GRP - 1) / GRP;
    localparam int PAD_W = NGRP * GRP;
    localparam int GW    = 3;

    logic [PAD_W-1:0] padded;
    logic [GW-1:0]    part [NGRP];

    assign padded = {{(PAD_W - W){1'b0}}, bits_i};

    for (genvar g = 0; g < NGRP; g++) begin : g_group
        always_comb begin
            part[g] = '0;
            for (int b = 0; b < GRP; b++) begin
                part[g] = part[g] + GW'(padded[g*GRP + b]);
            end
        end
    end

    always_comb begin
        count_o = '0;
        for (int g = 0; g < NGRP; g++) begin
            count_o = count_o + OW'(part[g]);
        end
    end

endmodule

// File: rtl/rop_quantizer_backend.sv
module rop_quantizer_backend
    import rop_pkg::*;
#(
    parameter int N  = DEF_STAGES,
    localparam int CW = code_width(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [N-1:0]  taps_i,
    output logic [N-1:0]  trans_vec_o,
    output logic [CW-1:0] code_o,
    output logic          ovr_o
);

    logic [N-1:0]  cur_s;
    logic [N-1:0]  prev_s;
    logic          ready_s;
    logic [N-1:0]  flip_s;
    logic [CW-1:0] sum_s;

    rop_tap_capture #(.N(N)) u_capture (
        .clk     (clk),
        .rst     (rst),
        .taps_i  (taps_i),
        .cur_o   (cur_s),
        .prev_o  (prev_s),
        .ready_o (ready_s)
    );

    rop_edge_detect #(.N(N)) u_detect (
        .cur_i  (cur_s),
        .prev_i (prev_s),
        .flip_o (flip_s)
    );

    rop_popcount #(.W(N), .OW(CW)) u_count (
        .bits_i  (flip_s),
        .count_o (sum_s)
    );

    always_ff @(posedge clk) begin
        if (rst || !ready_s) begin
            trans_vec_o <= '0;
            code_o      <= '0;
            ovr_o       <= 1'b0;
        end else begin
            trans_vec_o <= flip_s;
            code_o      <= sum_s;
            ovr_o       <= (sum_s == CW'(N));
        end
    end

    // R3: code never exceeds stage count
    p_code_range_r3: assert property (@(posedge clk) disable iff (rst)
        code_o <= CW'(N));

    // R3: code agrees with the vector it travels with
    p_code_match_r3: assert property (@(posedge clk) disable iff (rst)
        $countones(trans_vec_o) == int'(code_o));

    // R5: flag only with every stage marked
    p_ovr_full_r5: assert property (@(posedge clk) disable iff (rst)
        ovr_o |-> (trans_vec_o == '1));

    // R1: first cycle after reset shows nothing
    p_quiet_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (code_o == '0 && trans_vec_o == '0 && !ovr_o));

endmodule

// File: tb/rop_quantizer_backend_test.sv
module rop_quantizer_backend_test;

    localparam int N      = 15;
    localparam int CW     = $clog2(N + 1);
    localparam int PERIOD = 10;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [N-1:0]  taps = '0;
    logic [N-1:0]  trans_vec;
    logic [CW-1:0] code;
    logic          ovr;

    int checks = 0;
    int fails  = 0;
    int edges  = 0;
    int phase  = 0;
    bit done   = 1'b0;
    logic [N-1:0] h0 = '0, h1 = '0, h2 = '0;

    always #(PERIOD/2) clk = ~clk;

    rop_quantizer_backend #(.N(N)) uut (
        .clk         (clk),
        .rst         (rst),
        .taps_i      (taps),
        .trans_vec_o (trans_vec),
        .code_o      (code),
        .ovr_o       (ovr)
    );

    // twisted ring: each unit of phase flips exactly one stage
    function automatic logic [N-1:0] ring_taps(input int p);
        logic [N-1:0] t;
        int pm = p % (2*N);
        for (int i = 0; i < N; i++) begin
            if (pm <= N) t[i] = (pm > i);
            else         t[i] = !((pm - N) > i);
        end
        return t;
    endfunction

    task automatic check_val(input string req, input string what,
                             input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // advance one edge, then compare all outputs with the bench model
    task automatic tick_check(input string req);
        logic [N-1:0] ev;
        int ec;
        @(posedge clk);
        #1;
        if (rst) begin
            edges = 0; h0 = '0; h1 = '0; h2 = '0;
            ev = '0;
        end else begin
            h2 = h1; h1 = h0; h0 = taps;
            edges++;
            ev = (edges >= 3) ? (h1 ^ h2) : '0;
        end
        ec = $countones(ev);
        check_val(req, "vector", int'(trans_vec), int'(ev));
        check_val(req, "code",   int'(code),      ec);
        check_val(req, "ovr",    int'(ovr),       int'(ec == N));
    endtask

    task automatic drive_step(input int m);
        phase = phase + m;
        taps  = ring_taps(phase);
    endtask

    task automatic t_reset;
        rst = 1'b1;
        for (int c = 0; c < 4; c++) begin
            drive_step(5);
            tick_check("R1");
        end
        rst = 1'b0;
        for (int c = 0; c < 3; c++) begin
            drive_step(7);
            tick_check("R1");
        end
    endtask

    task automatic t_static;
        for (int c = 0; c < 6; c++) tick_check("R7");
        check_val("R7", "held code", int'(code), 0);
    endtask

    task automatic t_rate(input int m, input string req);
        for (int c = 0; c < 3*N; c++) begin
            drive_step(m);
            tick_check(req);
        end
        check_val(req, "settled code", int'(code), (m <= N) ? m : 2*N - m);
    endtask

    task automatic t_rate_change;
        // R6: code follows a rate change two edges after the first new sample
        for (int c = 0; c < 4; c++) begin drive_step(3); tick_check("R6"); end
        drive_step(9);
        tick_check("R6");
        check_val("R6", "before change", int'(code), 3);
        tick_check("R6");
        check_val("R6", "after change", int'(code), 9);
    endtask

    task automatic t_single;
        // R2: one stage flipping alone, at each stage
        for (int i = 0; i < N; i++) begin
            taps = taps ^ (N'(1) << i);
            tick_check("R2");
            tick_check("R2");
            check_val("R2", "single vec", int'(trans_vec), int'(N'(1) << i));
        end
    endtask

    initial begin
        t_reset();
        t_static();
        t_rate(1, "R4");
        t_rate(4, "R4");
        t_rate(11, "R3");
        t_rate(N, "R5");
        t_rate(N + 2, "R8");
        t_rate(0, "R7");
        t_rate_change();
        t_single();
        rst = 1'b1;
        tick_check("R1");
        tick_check("R1");
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(PERIOD * 200000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule